// File: doc/BRIEF.md
# Row Conversion and Readout Sequencer

This block drives a sensor whose columns are digitized in parallel, one pixel row at a time. After a start strobe it walks a window of rows from a first to a last index. For each row it presents the row index on a 10-bit address bus and issues a one-cycle active-low start pulse. It then waits for the sensor's active-low completion acknowledgement. When the acknowledgement arrives, it moves the converted row into the sensor's output shift register with a one-cycle active-low load pulse.

Readout is pipelined. While row N converts, the data of row N-1 streams out under an active-low read enable that stays asserted for a programmable number of cycles. The first row of a frame therefore has no read window in front of it. After the last row is loaded, one trailing read window drains the pipeline with no new start pulse, and a frame-done pulse follows. If the acknowledgement does not come within a programmable number of cycles, the sequencer raises a one-cycle timeout flag and returns to idle.

Top module: `row_readout_seq`

## Requirements
- R1: While reset is active and on the first cycle after it, the start, load and read-enable strobes are high (inactive), frame-done and timeout are low, and the row address and row index are 0.
- R2: A start strobe sampled high while idle, with first row <= last row, gives a row start pulse (low for exactly one cycle) in the next cycle, with the address equal to the first row. A start strobe sampled during a frame, or with first row > last row, has no effect on any output.
- R3: The row address changes only in the cycle in which a row start pulse is low. It then holds until the next row's start pulse, which covers the whole wait for the acknowledgement. The row index output always equals the address.
- R4: A row is loaded only after the acknowledgement has been seen low on a cycle after that row's start pulse. A one-cycle acknowledgement is remembered until it is used.
- R5: Each row is loaded with a load pulse that is low for exactly one cycle. Read enable is then low for exactly the read-length number of consecutive cycles, starting in the cycle after the load pulse. A read length of 0 gives no read-enable cycles.
- R6: A load pulse never coincides with read enable. A row's load follows, by exactly one cycle, the later of its acknowledgement and the last read-enable cycle of the previous row.
- R7: Rows are converted in ascending order, first to last inclusive, one step per row. Each later row's start pulse falls in the same cycle as the first read-enable cycle of the previous row.
- R8: After the last row's load no further start pulse is issued. Frame-done is high for one cycle, in the cycle after the last read-enable cycle of the drain window (two cycles after the last load when the read length is 0). It is never high together with any strobe.
- R9: With a nonzero timeout limit T, if the acknowledgement stays high for T consecutive cycles after a start pulse, the timeout flag is high for one cycle in the next cycle. No load pulse follows, and the sequencer returns to idle.
- R10: A timeout limit of 0 disables the timeout. An acknowledgement that arrives in the T-th cycle after the start pulse still counts in time.
- R11: First row, last row, read length and timeout limit are captured when a frame starts. Changes to them during the frame have no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Frame start strobe |
| first_row_i | input | 10 | First row of the window |
| last_row_i | input | 10 | Last row of the window |
| read_len_i | input | 12 | Read-enable cycles per row |
| tmo_limit_i | input | 16 | Acknowledgement timeout in cycles, 0 disables |
| row_done_n_i | input | 1 | Row conversion acknowledgement from the sensor, active low |
| row_addr_o | output | 10 | Row address to the sensor |
| row_strt_n_o | output | 1 | Row start pulse, active low |
| ld_shft_n_o | output | 1 | Load output shift register pulse, active low |
| data_read_en_n_o | output | 1 | Data read enable, active low |
| cur_row_o | output | 10 | Index of the row being converted |
| frame_done_o | output | 1 | One-cycle frame completion pulse |
| timeout_err_o | output | 1 | One-cycle acknowledgement timeout flag |

## Verification
On every cycle the bound assertions check the local shape of the strobes. Start and load pulses last one cycle, the address moves only under a start pulse and holds across the next cycle, load never overlaps read enable, and frame-done and the timeout flag are single-cycle and quiet. Only the bench scenarios show the frame-level behaviour: row order, the exact cycle of each load relative to slow acknowledgements versus long read windows, the drain and frame-done timing, the timeout boundary at exactly T cycles, the disabled timeout, and that a start strobe or configuration changes during a frame do nothing.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
    typedef enum logic [2:0] {
        SQ_IDLE  = 3'd0,
        SQ_START = 3'd1,
        SQ_CONV  = 3'd2,
        SQ_LOAD  = 3'd3,
        SQ_DRAIN = 3'd4,
        SQ_FIN   = 3'd5,
        SQ_ERR   = 3'd6
    } seq_state_e;
endpackage

// File: rtl/rrs_read_timer.sv
// Counts the read-enable window for one row of output data.
module rrs_read_timer #(
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [LEN_W-1:0] len_i,
    output logic             busy_o,
    output logic             ending_o
);
    typedef struct packed {
        logic [LEN_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (load_i) begin
            tmr_d.cnt = len_i;
        end else if (tmr_q.cnt != '0) begin
            tmr_d.cnt = tmr_q.cnt - LEN_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign busy_o   = (tmr_q.cnt != '0);
    assign ending_o = (tmr_q.cnt <= LEN_W'(1));
endmodule

// File: rtl/rrs_done_watch.sv
// Latches the sensor acknowledgement and times out a missing one.
module rrs_done_watch #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             arm_i,
    input  logic             done_n_i,
    input  logic [TMO_W-1:0] limit_i,
    output logic             done_o,
    output logic             expire_o
);
    typedef struct packed {
        logic             seen;
        logic [TMO_W-1:0] cnt;
    } wd_t;

    wd_t wd_d, wd_q;

    always_comb begin
        wd_d = wd_q;
        if (clear_i) begin
            wd_d.seen = 1'b0;
            wd_d.cnt  = '0;
        end else if (arm_i) begin
            if (!done_n_i) begin
                wd_d.seen = 1'b1;
            end else if (!wd_q.seen) begin
                wd_d.cnt = wd_q.cnt + TMO_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wd_q <= '0;
        end else begin
            wd_q <= wd_d;
        end
    end

    assign done_o   = wd_q.seen | (arm_i & ~done_n_i);
    assign expire_o = arm_i & ~wd_q.seen & done_n_i & (limit_i != '0)
                      & (wd_q.cnt == (limit_i - TMO_W'(1)));
endmodule

// File: rtl/row_readout_seq.sv
module row_readout_seq #(
    parameter int ROW_W = 10,
    parameter int LEN_W = 12,
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [ROW_W-1:0] first_row_i,
    input  logic [ROW_W-1:0] last_row_i,
    input  logic [LEN_W-1:0] read_len_i,
    input  logic [TMO_W-1:0] tmo_limit_i,
    input  logic             row_done_n_i,
    output logic [ROW_W-1:0] row_addr_o,
    output logic             row_strt_n_o,
    output logic             ld_shft_n_o,
    output logic             data_read_en_n_o,
    output logic [ROW_W-1:0] cur_row_o,
    output logic             frame_done_o,
    output logic             timeout_err_o
);
    import rrs_pkg::*;

    typedef struct packed {
        seq_state_e       state;
        logic [ROW_W-1:0] row;
        logic [ROW_W-1:0] last;
        logic [LEN_W-1:0] rlen;
        logic [TMO_W-1:0] tlim;
    } seq_t;

    seq_t seq_d, seq_q;

    logic rd_busy, rd_ending;
    logic ack_done, ack_expire;

    rrs_read_timer #(.LEN_W(LEN_W)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (seq_q.state == SQ_LOAD),
        .len_i    (seq_q.rlen),
        .busy_o   (rd_busy),
        .ending_o (rd_ending)
    );

    rrs_done_watch #(.TMO_W(TMO_W)) u_ack (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (seq_q.state == SQ_START),
        .arm_i    (seq_q.state == SQ_CONV),
        .done_n_i (row_done_n_i),
        .limit_i  (seq_q.tlim),
        .done_o   (ack_done),
        .expire_o (ack_expire)
    );

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.state)
            SQ_IDLE: begin
                if (start_i && (first_row_i <= last_row_i)) begin
                    seq_d.row   = first_row_i;
                    seq_d.last  = last_row_i;
                    seq_d.rlen  = read_len_i;
                    seq_d.tlim  = tmo_limit_i;
                    seq_d.state = SQ_START;
                end
            end
            SQ_START: seq_d.state = SQ_CONV;
            SQ_CONV: begin
                if (ack_done && rd_ending) begin
                    seq_d.state = SQ_LOAD;
                end else if (ack_expire) begin
                    seq_d.state = SQ_ERR;
                end
            end
            SQ_LOAD: begin
                if (seq_q.row == seq_q.last) begin
                    seq_d.state = SQ_DRAIN;
                end else begin
                    seq_d.row   = seq_q.row + ROW_W'(1);
                    seq_d.state = SQ_START;
                end
            end
            SQ_DRAIN: begin
                if (rd_ending) begin
                    seq_d.state = SQ_FIN;
                end
            end
            SQ_FIN:  seq_d.state = SQ_IDLE;
            SQ_ERR:  seq_d.state = SQ_IDLE;
            default: seq_d.state = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q       <= '0;
            seq_q.state <= SQ_IDLE;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign row_addr_o       = seq_q.row;
    assign cur_row_o        = seq_q.row;
    assign row_strt_n_o     = (seq_q.state != SQ_START);
    assign ld_shft_n_o      = (seq_q.state != SQ_LOAD);
    assign data_read_en_n_o = ~rd_busy;
    assign frame_done_o     = (seq_q.state == SQ_FIN);
    assign timeout_err_o    = (seq_q.state == SQ_ERR);
endmodule

// File: rtl/rrs_seq_checker.sv
module rrs_seq_checker #(
    parameter int ROW_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic [ROW_W-1:0] row_addr_o,
    input logic             row_strt_n_o,
    input logic             ld_shft_n_o,
    input logic             data_read_en_n_o,
    input logic             frame_done_o,
    input logic             timeout_err_o
);
    assert_strt_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !row_strt_n_o |=> row_strt_n_o);

    assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !row_strt_n_o |=> $stable(row_addr_o));

    assert_addr_moves_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (row_addr_o != $past(row_addr_o)) |-> !row_strt_n_o);

    assert_ld_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_shft_n_o |=> ld_shft_n_o);

    assert_ld_no_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ld_shft_n_o && !data_read_en_n_o));

    assert_fd_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done_o |-> (row_strt_n_o && ld_shft_n_o && data_read_en_n_o && !timeout_err_o));

    assert_fd_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done_o |=> !frame_done_o);

    assert_err_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err_o |=> (!timeout_err_o && row_strt_n_o && ld_shft_n_o));
endmodule

bind row_readout_seq rrs_seq_checker #(.ROW_W(ROW_W)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .row_addr_o       (row_addr_o),
    .row_strt_n_o     (row_strt_n_o),
    .ld_shft_n_o      (ld_shft_n_o),
    .data_read_en_n_o (data_read_en_n_o),
    .frame_done_o     (frame_done_o),
    .timeout_err_o    (timeout_err_o)
);

// File: tb/sim_row_readout_seq.sv
module sim_row_readout_seq;
    localparam int CLK_PERIOD = 10;
    localparam int NC = 2048;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [9:0]  first_row_i = '0;
    logic [9:0]  last_row_i = '0;
    logic [11:0] read_len_i = '0;
    logic [15:0] tmo_limit_i = '0;
    logic        row_done_n_i = 1'b1;
    logic [9:0]  row_addr_o, cur_row_o;
    logic        row_strt_n_o, ld_shft_n_o, data_read_en_n_o, frame_done_o, timeout_err_o;

    int checks = 0;
    int fails = 0;
    int prev_addr = 0;

    bit e_strt [NC];
    bit e_ld   [NC];
    bit e_rd   [NC];
    bit e_fd   [NC];
    bit e_err  [NC];
    bit e_done [NC];
    int e_addr [NC];

    always #(CLK_PERIOD/2) clk = ~clk;

    row_readout_seq u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .first_row_i(first_row_i), .last_row_i(last_row_i),
        .read_len_i(read_len_i), .tmo_limit_i(tmo_limit_i),
        .row_done_n_i(row_done_n_i), .row_addr_o(row_addr_o),
        .row_strt_n_o(row_strt_n_o), .ld_shft_n_o(ld_shft_n_o),
        .data_read_en_n_o(data_read_en_n_o), .cur_row_o(cur_row_o),
        .frame_done_o(frame_done_o), .timeout_err_o(timeout_err_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp, input int t);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s cycle %0d: actual %0d expected %0d", req, what, t, act, exp);
        end
    endtask

    task automatic clear_model();
        for (int i = 0; i < NC; i++) begin
            e_strt[i] = 0; e_ld[i] = 0; e_rd[i] = 0; e_fd[i] = 0;
            e_err[i] = 0; e_done[i] = 0; e_addr[i] = prev_addr;
        end
    endtask

    task automatic check_cycle(input int t);
        chk("R2/R7", "row_strt_n", int'(row_strt_n_o), int'(!e_strt[t]), t);
        chk("R4/R5/R6", "ld_shft_n", int'(ld_shft_n_o), int'(!e_ld[t]), t);
        chk("R5", "data_read_en_n", int'(data_read_en_n_o), int'(!e_rd[t]), t);
        chk("R8", "frame_done", int'(frame_done_o), int'(e_fd[t]), t);
        chk("R9/R10", "timeout_err", int'(timeout_err_o), int'(e_err[t]), t);
        chk("R3", "row_addr", int'(row_addr_o), e_addr[t], t);
        chk("R3", "cur_row", int'(cur_row_o), e_addr[t], t);
    endtask

    // Cycle t is the period after clock edge t; start is driven in cycle 0.
    task automatic run_frame(input int first, input int last, input int len,
                             input int dly, input int lim, input bit tmo, input bit disturb);
        int s, ld, c, fin, endc;
        clear_model();
        s = 1;
        if (tmo) begin
            e_strt[1] = 1;
            for (int i = 1; i < NC; i++) e_addr[i] = first;
            e_err[2 + lim] = 1;
            endc = lim + 6;
            prev_addr = first;
        end else begin
            ld = 0;
            for (int k = 0; k <= last - first; k++) begin
                e_strt[s] = 1;
                for (int i = s; i < NC; i++) e_addr[i] = first + k;
                e_done[s + dly] = 1;
                if (k == 0) c = s + dly;
                else c = s + ((dly > len - 1) ? dly : len - 1);
                ld = c + 1;
                e_ld[ld] = 1;
                for (int i = 1; i <= len; i++) e_rd[ld + i] = 1;
                s = ld + 1;
            end
            fin = ld + ((len > 1) ? len : 1) + 1;
            e_fd[fin] = 1;
            endc = fin + 3;
            prev_addr = last;
        end
        for (int t = 0; t <= endc; t++) begin
            @(negedge clk);
            check_cycle(t);
            start_i      = (t == 0);
            row_done_n_i = !e_done[t];
            if (t == 0) begin
                first_row_i = 10'(first);
                last_row_i  = 10'(last);
                read_len_i  = 12'(len);
                tmo_limit_i = 16'(lim);
            end
            if (disturb && t == 4) begin
                // R11 / R2: mid-frame start and new settings must do nothing
                start_i     = 1'b1;
                first_row_i = 10'd0;
                last_row_i  = 10'(first);
                read_len_i  = 12'(len + 7);
                tmo_limit_i = 16'd1;
            end
        end
        start_i = 1'b0;
        row_done_n_i = 1'b1;
    endtask

    // R2: start with first row above last row is ignored
    task automatic run_ignored(input int first, input int last);
        clear_model();
        for (int t = 0; t <= 10; t++) begin
            @(negedge clk);
            check_cycle(t);
            start_i = (t == 0);
            if (t == 0) begin
                first_row_i = 10'(first);
                last_row_i  = 10'(last);
            end
        end
        start_i = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        clear_model();
        repeat (3) @(negedge clk);
        check_cycle(0);            // R1 during reset
        rst_n = 1'b1;
        @(negedge clk);
        check_cycle(0);            // R1 after reset
        run_frame(0, 3, 4, 2, 0, 0, 0);       // R6: read window longer than conversion
        run_frame(10, 12, 2, 6, 20, 0, 0);    // R4: slow acknowledgement
        run_frame(1021, 1023, 0, 1, 5, 0, 0); // R5/R8: zero read length, top rows
        run_frame(7, 7, 3, 3, 0, 0, 0);       // R7/R8: single row
        run_frame(100, 104, 1, 1, 0, 0, 0);   // R5: one-cycle read window
        run_frame(20, 23, 5, 3, 10, 0, 1);    // R11: disturbed settings
        run_frame(50, 52, 3, 0, 4, 1, 0);     // R9: timeout after 4 cycles
        run_frame(30, 31, 2, 5, 5, 0, 0);     // R10: acknowledgement at limit
        run_frame(60, 61, 2, 40, 0, 0, 0);    // R10: limit 0 disables timeout
        run_ignored(9, 3);                    // R2: first above last
        run_frame(200, 201, 2, 2, 8, 0, 0);   // R2: recovers after ignored start
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule